// File: doc/BRIEF.md
# Accumulator Adder and Logic Unit

This block computes and holds the next value of a 16-bit accumulator (AC) and its one-bit extend flag (E). A control unit elsewhere decodes each instruction into a set of one-cycle operation strobes. On each rising clock edge the strobe that is high picks the operation that produces the new AC and E. The operations are: bitwise AND with the data register, add with carry into E, transfer from the data register, load of the low byte from an input register, complement, clear, increment, rotate right or left through E, clear E and complement E.

The datapath is a row of identical per-bit stages. Each stage holds a full adder and the logic and rotate selection for its bit. One carry chain runs through the row and serves both add and increment. A separate flag stage chooses the next E from the carry out, the bit rotated out, or the flag operations. When the input-byte load is chosen, the block also raises a strobe in the same cycle that tells the input side to clear its data-ready flag.

Top module: `acc_alu_unit`

## Requirements
- R1: While rst_n is low, ac_q reads 0 and e_q reads 0.
- R2: When do_and is high at a clock edge, ac_q becomes ac_q AND dr_in, and e_q is unchanged.
- R3: When do_add is high, {e_q, ac_q} becomes the 17-bit sum ac_q + dr_in. The carry out of bit 15 lands in e_q.
- R4: When do_xfer is high, ac_q becomes dr_in, and e_q is unchanged.
- R5: When do_inp is high, ac_q[7:0] becomes inpr_in, ac_q[15:8] and e_q keep their values, and in_flag_clr is high during that same cycle. In any other cycle in_flag_clr is low.
- R6: When do_cma is high, every bit of ac_q is inverted, and e_q is unchanged.
- R7: When do_cla is high, ac_q becomes 0, and e_q is unchanged.
- R8: When do_inc is high, ac_q becomes ac_q + 1 modulo 2^16, so 0xFFFF wraps to 0. e_q is not modified.
- R9: When do_cir is high, ac_q shifts right one place, the old e_q enters bit 15, and the old bit 0 goes into e_q.
- R10: When do_cil is high, ac_q shifts left one place, the old e_q enters bit 0, and the old bit 15 goes into e_q.
- R11: do_cle clears e_q and do_cme inverts e_q. Both leave ac_q unchanged.
- R12: At most one do_* strobe is high in any cycle. When none is high, ac_q and e_q hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| do_and | input | 1 | AND with data register |
| do_add | input | 1 | Add data register, carry into E |
| do_xfer | input | 1 | Copy data register into AC |
| do_inp | input | 1 | Load input byte into AC low byte |
| do_cma | input | 1 | Invert AC |
| do_cla | input | 1 | Zero AC |
| do_inc | input | 1 | AC plus one |
| do_cir | input | 1 | Rotate AC and E right |
| do_cil | input | 1 | Rotate AC and E left |
| do_cle | input | 1 | Zero E |
| do_cme | input | 1 | Invert E |
| dr_in | input | 16 | Data register value |
| inpr_in | input | 8 | Input character register value |
| ac_q | output | 16 | Accumulator |
| e_q | output | 1 | Extend flag |
| in_flag_clr | output | 1 | Request to clear the input-ready flag |

## Verification
The bench builds the block with its defaults: a 16-bit accumulator and an 8-bit input register. The input register being narrower than the accumulator lets the bench observe that the input load leaves the upper byte intact. The full 16-bit width lets it drive the carry out of bit 15 and the wrap from 0xFFFF. Rotate sequences that run long enough pass bits through E and back, so stuck or swapped end bits show up at the ports.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [3:0] {
    OP_HOLD = 4'd0,
    OP_AND  = 4'd1,
    OP_ADD  = 4'd2,
    OP_XFER = 4'd3,
    OP_INP  = 4'd4,
    OP_CMA  = 4'd5,
    OP_CLA  = 4'd6,
    OP_INC  = 4'd7,
    OP_CIR  = 4'd8,
    OP_CIL  = 4'd9,
    OP_CLE  = 4'd10,
    OP_CME  = 4'd11
  } acc_op_e;

  localparam int NUM_CTL = 11;

  // one-bit full adder: returns {carry_out, sum}
  function automatic logic [1:0] full_add(input logic a, input logic b, input logic c);
    logic s;
    logic co;
    s  = a ^ b ^ c;
    co = (a & b) | (a & c) | (b & c);
    return {co, s};
  endfunction

endpackage

// File: rtl/acc_op_decode.sv
module acc_op_decode
  import acc_pkg::*;
(
  input  logic [NUM_CTL-1:0] ctl,
  output acc_op_e            op
);
  // lowest-index strobe wins; callers keep at most one high
  always_comb begin
    op = OP_HOLD;
    for (int k = NUM_CTL - 1; k >= 0; k--) begin
      if (ctl[k]) op = acc_op_e'(k + 1);
    end
  end
endmodule

// File: rtl/acc_bit_slice.sv
module acc_bit_slice
  import acc_pkg::*;
(
  input  acc_op_e op,
  input  logic    ac_b,
  input  logic    dr_b,
  input  logic    in_b,
  input  logic    in_valid,
  input  logic    lo_nbr,
  input  logic    hi_nbr,
  input  logic    c_in,
  output logic    next_b,
  output logic    c_out
);
  logic       addend;
  logic [1:0] fa;

  assign addend = (op == OP_ADD) ? dr_b : 1'b0;
  assign fa     = full_add(ac_b, addend, c_in);
  assign c_out  = fa[1];

  always_comb begin
    unique case (op)
      OP_AND:         next_b = ac_b & dr_b;
      OP_ADD, OP_INC: next_b = fa[0];
      OP_XFER:        next_b = dr_b;
      OP_INP:         next_b = in_valid ? in_b : ac_b;
      OP_CMA:         next_b = ~ac_b;
      OP_CLA:         next_b = 1'b0;
      OP_CIR:         next_b = hi_nbr;
      OP_CIL:         next_b = lo_nbr;
      default:        next_b = ac_b;
    endcase
  end
endmodule

// File: rtl/acc_flag_next.sv
module acc_flag_next
  import acc_pkg::*;
(
  input  acc_op_e op,
  input  logic    e_cur,
  input  logic    carry_top,
  input  logic    ac_lsb,
  input  logic    ac_msb,
  output logic    e_next
);
  always_comb begin
    unique case (op)
      OP_ADD:  e_next = carry_top;
      OP_CIR:  e_next = ac_lsb;
      OP_CIL:  e_next = ac_msb;
      OP_CLE:  e_next = 1'b0;
      OP_CME:  e_next = ~e_cur;
      default: e_next = e_cur;
    endcase
  end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IN_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_and,
  input  logic              do_add,
  input  logic              do_xfer,
  input  logic              do_inp,
  input  logic              do_cma,
  input  logic              do_cla,
  input  logic              do_inc,
  input  logic              do_cir,
  input  logic              do_cil,
  input  logic              do_cle,
  input  logic              do_cme,
  input  logic [DATA_W-1:0] dr_in,
  input  logic [IN_W-1:0]   inpr_in,
  output logic [DATA_W-1:0] ac_q,
  output logic              e_q,
  output logic              in_flag_clr
);
  localparam int MSB = DATA_W - 1;

  acc_op_e             op_sel;
  logic [NUM_CTL-1:0]  ctl_vec;
  logic [DATA_W-1:0]   ac_next;
  logic [DATA_W:0]     carry;
  logic                e_next;
  logic                add_carry;   // carry out of the top stage, seen by the checker

  assign ctl_vec = {do_cme, do_cle, do_cil, do_cir, do_inc, do_cla,
                    do_cma, do_inp, do_xfer, do_add, do_and};

  acc_op_decode u_dec (
    .ctl (ctl_vec),
    .op  (op_sel)
  );

  assign carry[0] = (op_sel == OP_INC);

  for (genvar i = 0; i < DATA_W; i++) begin : g_slice
    logic in_bit;
    logic lo_src;
    logic hi_src;
    if (i < IN_W) begin : g_in
      assign in_bit = inpr_in[i];
    end else begin : g_noin
      assign in_bit = 1'b0;
    end
    if (i == 0) begin : g_lo_e
      assign lo_src = e_q;
    end else begin : g_lo_ac
      assign lo_src = ac_q[i-1];
    end
    if (i == MSB) begin : g_hi_e
      assign hi_src = e_q;
    end else begin : g_hi_ac
      assign hi_src = ac_q[i+1];
    end
    acc_bit_slice u_bit (
      .op       (op_sel),
      .ac_b     (ac_q[i]),
      .dr_b     (dr_in[i]),
      .in_b     (in_bit),
      .in_valid (i < IN_W),
      .lo_nbr   (lo_src),
      .hi_nbr   (hi_src),
      .c_in     (carry[i]),
      .next_b   (ac_next[i]),
      .c_out    (carry[i+1])
    );
  end

  assign add_carry = carry[DATA_W];

  acc_flag_next u_flag (
    .op        (op_sel),
    .e_cur     (e_q),
    .carry_top (add_carry),
    .ac_lsb    (ac_q[0]),
    .ac_msb    (ac_q[MSB]),
    .e_next    (e_next)
  );

  assign in_flag_clr = (op_sel == OP_INP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= '0;
      e_q  <= 1'b0;
    end else begin
      ac_q <= ac_next;
      e_q  <= e_next;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DATA_W = 16,
  parameter int IN_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              do_and,
  input logic              do_add,
  input logic              do_xfer,
  input logic              do_inp,
  input logic              do_cma,
  input logic              do_cla,
  input logic              do_inc,
  input logic              do_cir,
  input logic              do_cil,
  input logic              do_cle,
  input logic              do_cme,
  input logic [DATA_W-1:0] dr_in,
  input logic [IN_W-1:0]   inpr_in,
  input logic [DATA_W-1:0] ac_q,
  input logic              e_q,
  input logic              in_flag_clr,
  input logic              add_carry
);
  logic [10:0] ctls;
  assign ctls = {do_cme, do_cle, do_cil, do_cir, do_inc, do_cla,
                 do_cma, do_inp, do_xfer, do_add, do_and};

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (ac_q == '0 && !e_q));

  a_r2_and: assert property (@(posedge clk) disable iff (!rst_n)
    do_and |=> (ac_q == ($past(ac_q) & $past(dr_in))) && e_q == $past(e_q));

  a_r3_add: assert property (@(posedge clk) disable iff (!rst_n)
    do_add |=> {e_q, ac_q} == ({1'b0, $past(ac_q)} + {1'b0, $past(dr_in)}));

  a_r3_carry_seen: assert property (@(posedge clk) disable iff (!rst_n)
    do_add |=> e_q == $past(add_carry));

  a_r5_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    do_inp |=> ac_q[IN_W-1:0] == $past(inpr_in) && $stable(ac_q[DATA_W-1:IN_W]) && $stable(e_q));

  a_r5_flag_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_flag_clr == do_inp);

  a_r6_cma: assert property (@(posedge clk) disable iff (!rst_n)
    do_cma |=> ac_q == ~$past(ac_q));

  a_r8_inc_keeps_e: assert property (@(posedge clk) disable iff (!rst_n)
    do_inc |=> $stable(e_q) && ac_q == $past(ac_q) + 1'b1);

  a_r9_cir: assert property (@(posedge clk) disable iff (!rst_n)
    do_cir |=> {ac_q, e_q} == {$past(e_q), $past(ac_q)});

  a_r10_cil: assert property (@(posedge clk) disable iff (!rst_n)
    do_cil |=> {e_q, ac_q} == {$past(ac_q), $past(e_q)});

  a_r11_e_ops_keep_ac: assert property (@(posedge clk) disable iff (!rst_n)
    (do_cle || do_cme) |=> $stable(ac_q));

  a_r12_single_ctl: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ctls));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctls == '0) |=> $stable(ac_q) && $stable(e_q));
endmodule

bind acc_alu_unit acc_alu_chk #(.DATA_W(DATA_W), .IN_W(IN_W)) u_chk (.*);

// File: tb/tb_acc_alu_unit.sv
module tb_acc_alu_unit;
  localparam int DW = 16;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic do_and = 0, do_add = 0, do_xfer = 0, do_inp = 0, do_cma = 0, do_cla = 0;
  logic do_inc = 0, do_cir = 0, do_cil = 0, do_cle = 0, do_cme = 0;
  logic [DW-1:0] dr_in = '0;
  logic [IW-1:0] inpr_in = '0;
  logic [DW-1:0] ac_q;
  logic          e_q;
  logic          in_flag_clr;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] m_ac = '0;
  logic          m_e = 1'b0;

  always #5 clk = ~clk;

  acc_alu_unit dut (
    .clk(clk), .rst_n(rst_n),
    .do_and(do_and), .do_add(do_add), .do_xfer(do_xfer), .do_inp(do_inp),
    .do_cma(do_cma), .do_cla(do_cla), .do_inc(do_inc), .do_cir(do_cir),
    .do_cil(do_cil), .do_cle(do_cle), .do_cme(do_cme),
    .dr_in(dr_in), .inpr_in(inpr_in),
    .ac_q(ac_q), .e_q(e_q), .in_flag_clr(in_flag_clr)
  );

  // op codes: 0 hold,1 and,2 add,3 xfer,4 inp,5 cma,6 cla,7 inc,8 cir,9 cil,10 cle,11 cme
  function automatic logic [DW:0] model(int code, logic [DW-1:0] a, logic e,
                                        logic [DW-1:0] d, logic [IW-1:0] p);
    logic [DW:0] r;
    r = {e, a};
    case (code)
      1:  r = {e, a & d};
      2:  r = {1'b0, a} + {1'b0, d};
      3:  r = {e, d};
      4:  r = {e, a[DW-1:IW], p};
      5:  r = {e, ~a};
      6:  r = {e, {DW{1'b0}}};
      7:  r = {e, a + 16'd1};
      8:  r = {a[0], e, a[DW-1:1]};
      9:  r = {a[DW-1], a[DW-2:0], e};
      10: r = {1'b0, a};
      11: r = {~e, a};
      default: r = {e, a};
    endcase
    return r;
  endfunction

  function automatic string tag_of(int code);
    case (code)
      1: return "R2";  2: return "R3";  3: return "R4";  4: return "R5";
      5: return "R6";  6: return "R7";  7: return "R8";  8: return "R9";
      9: return "R10"; 10: return "R11"; 11: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_ctl(int code);
    do_and = (code == 1); do_add = (code == 2); do_xfer = (code == 3);
    do_inp = (code == 4); do_cma = (code == 5); do_cla = (code == 6);
    do_inc = (code == 7); do_cir = (code == 8); do_cil = (code == 9);
    do_cle = (code == 10); do_cme = (code == 11);
  endtask

  // called at a negedge; returns at the following negedge with results checked
  task automatic step(int code, logic [DW-1:0] d, logic [IW-1:0] p);
    logic [DW:0] r;
    string t;
    t = tag_of(code);
    set_ctl(code);
    dr_in = d;
    inpr_in = p;
    r = model(code, m_ac, m_e, d, p);
    #1;
    check("R5", {31'd0, in_flag_clr}, {31'd0, code == 4});
    @(posedge clk);
    @(negedge clk);
    set_ctl(0);
    m_ac = r[DW-1:0];
    m_e = r[DW];
    check(t, {16'd0, ac_q}, {16'd0, m_ac});
    check(t, {31'd0, e_q}, {31'd0, m_e});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {16'd0, ac_q}, 32'd0);
    check("R1", {31'd0, e_q}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    step(3, 16'hFFFF, 8'h00);       // R4 load all ones
    step(2, 16'h0001, 8'h00);       // R3 carry out: 0xFFFF+1 -> 0, E=1
    step(0, 16'h1234, 8'h55);       // R12 hold
    step(3, 16'hFFFF, 8'h00);
    step(7, 16'h0000, 8'h00);       // R8 wrap, E stays 1
    step(11, 16'h0000, 8'h00);      // R11 E -> 0
    step(3, 16'hA5C3, 8'h00);
    step(4, 16'h0000, 8'h3C);       // R5 high byte kept
    step(8, 16'h0000, 8'h00);       // R9
    step(9, 16'h0000, 8'h00);       // R10
    step(5, 16'h0000, 8'h00);       // R6
    step(1, 16'h0FF0, 8'h00);       // R2
    step(10, 16'h0000, 8'h00);      // R11 clear E
    step(6, 16'h0000, 8'h00);       // R7
    for (int k = 0; k < DW + 2; k++) step(9, 16'h0000, 8'h00); // R10 full rotate
    step(3, 16'h8001, 8'h00);
    for (int k = 0; k < DW + 2; k++) step(8, 16'h0000, 8'h00); // R9 full rotate

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int code;
      logic [DW-1:0] d;
      logic [IW-1:0] p;
      code = int'($urandom_range(0, 11));
      d = DW'($urandom);
      if ($urandom_range(0, 7) == 0) d = 16'hFFFF;
      p = IW'($urandom);
      step(code, d, p);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule